// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a 32-bit register datapath and a data memory that is addressed by bytes but read and written one 32-bit word at a time. For each request it adds a signed immediate to a base value to form the byte address. For a store it places the source bytes on the correct memory lanes and raises the matching byte-enable strobes. For a load it picks the addressed bytes out of the returned word and widens them to 32 bits, with zero or sign extension.

Byte order is big-endian. The most significant byte of a value sits at the lowest byte address, which is the most significant lane of the memory word. Bit order inside a byte does not change. A halfword must start on an even address and a word on a multiple of four. Any other halfword or word address, and the reserved size code, makes the request faulty. A faulty request does not reach memory. A faulty load still returns a result one cycle later, and that result is zero.

Top module: `be_lane_unit`

## Requirements
- R1: The byte address equals `base` plus `offset` sign-extended to the address width. `mem_addr` carries that address with its two low bits cleared.
- R2: A byte store at byte address A raises exactly one strobe, `mem_be` = 4'b1000 >> (A mod 4). That lane holds `st_data[7:0]`. Strobe bit 3 is the lane at offset 0, which is bits 31:24 of the word.
- R3: A halfword store writes only `st_data[15:0]`. Bits 15:8 go to the lower address and bits 7:0 to the next one. The strobes are 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R4: A word store raises all four strobes and writes `st_data` unchanged. Bits 31:24 land at the lowest address.
- R5: A byte load returns the byte at the addressed lane. With `req_signed` high it is sign-extended from bit 7, otherwise zero-extended. Size code 2'b00 means byte.
- R6: A halfword load returns the big-endian 16-bit value at the address, sign- or zero-extended according to `req_signed`. Size code 2'b01 means halfword.
- R7: A word load returns the four bytes with the lowest address as bits 31:24. Size code 2'b10 means word, and `req_signed` has no effect on it.
- R8: A halfword at an odd address, a word at an address that is not a multiple of four, or size code 2'b11 raises `fault` in the same cycle. The request then raises neither `mem_req` nor `mem_we`, and memory contents stay unchanged.
- R9: A faulty load still raises `ld_valid` one cycle later, with `ld_data` equal to zero.
- R10: `ld_valid` is high in the cycle after each load request and in no other cycle. Stores never raise it.
- R11: During and right after reset, `ld_valid` and `mem_req` are low while no request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend halfword and byte loads |
| base | input | 32 | Base register value |
| offset | input | 12 | Signed immediate byte offset |
| st_data | input | 32 | Store source register |
| mem_req | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned byte address to memory |
| mem_be | output | 4 | Byte strobes, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Word read from memory, one cycle after `mem_req` |
| fault | output | 1 | Misaligned or reserved-size request |
| ld_valid | output | 1 | Load result is valid |
| ld_data | output | 32 | Aligned and extended load result |

## Verification
A load's result comes back in the cycle after its request. A new store, or a new faulty request, can be presented in that same cycle. The bench issues a load and drives a store to another lane on the very next edge. It then checks the returned data against its byte-level model of memory, and in the same sample it checks the store's strobes and the fault flag. Later reads of the whole word show that the overlapping store wrote only its own lanes, and that the faulty stores wrote nothing.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN      = 32;
    localparam int NLANES    = XLEN / 8;
    localparam int LANE_BITS = $clog2(NLANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Captured at a load request, consumed when the memory word returns.
    typedef struct packed {
        logic                 bad;
        logic [LANE_BITS-1:0] lane;
        acc_size_e            size;
        logic                 sext;
    } ld_ctl_t;

    function automatic logic is_misaligned(acc_size_e sz, logic [LANE_BITS-1:0] lane);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lane[0];
            SZ_WORD: return |lane;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] widen(logic [XLEN-1:0] v, int unsigned bits, logic sext);
        logic [XLEN-1:0] mask;
        logic            msb;
        mask = (bits >= XLEN) ? '1 : ((XLEN'(1) << bits) - XLEN'(1));
        msb  = (bits >= XLEN) ? 1'b0 : v[bits-1];
        return (v & mask) | ((sext && msb) ? ~mask : '0);
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] word_addr,
    output logic [LANE_BITS-1:0] lane,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] eff;

    always_comb begin
        eff        = base + {{EXT_W{offset[OFF_W-1]}}, offset};
        lane       = eff[LANE_BITS-1:0];
        word_addr  = {eff[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
        misaligned = is_misaligned(size, lane);
    end
endmodule

// File: rtl/lsu_st_steer.sv
module lsu_st_steer
    import lsu_pkg::*;
(
    input  acc_size_e            size,
    input  logic [LANE_BITS-1:0] lane,
    input  logic [XLEN-1:0]      src,
    output logic [NLANES-1:0]    be,
    output logic [XLEN-1:0]      wdata
);
    // Strobe bit i / byte slot i is the lane at offset (NLANES-1-i).
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        localparam int OFS = NLANES - 1 - i;
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    be[i]          = (lane == OFS[LANE_BITS-1:0]);
                    wdata[8*i +: 8] = src[7:0];
                end
                SZ_HALF: begin
                    be[i]          = (lane[LANE_BITS-1:1] == OFS[LANE_BITS-1:1]);
                    wdata[8*i +: 8] = OFS[0] ? src[7:0] : src[15:8];
                end
                SZ_WORD: begin
                    be[i]          = 1'b1;
                    wdata[8*i +: 8] = src[8*i +: 8];
                end
                default: begin
                    be[i]          = 1'b0;
                    wdata[8*i +: 8] = 8'h00;
                end
            endcase
        end
    end
endmodule

// File: rtl/lsu_ld_align.sv
module lsu_ld_align
    import lsu_pkg::*;
(
    input  ld_ctl_t         ctl,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] result
);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b = rdata[8*(NLANES-1) +: 8];
        for (int i = 0; i < NLANES; i++) begin
            if (ctl.lane == LANE_BITS'(NLANES - 1 - i)) sel_b = rdata[8*i +: 8];
        end
        sel_h = ctl.lane[1] ? rdata[15:0] : rdata[31:16];

        if (ctl.bad) begin
            result = '0;
        end else begin
            case (ctl.size)
                SZ_BYTE: result = widen(XLEN'(sel_b), 8, ctl.sext);
                SZ_HALF: result = widen(XLEN'(sel_h), 16, ctl.sext);
                default: result = rdata;
            endcase
        end
    end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [31:0]       st_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              fault,
    output logic              ld_valid,
    output logic [31:0]       ld_data
);
    acc_size_e            size;
    logic [LANE_BITS-1:0] lane;
    logic                 misal;
    logic [NLANES-1:0]    be_raw;
    ld_ctl_t              ctl_q;

    assign size = acc_size_e'(req_size);

    lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
        .base       (base),
        .offset     (offset),
        .size       (size),
        .word_addr  (mem_addr),
        .lane       (lane),
        .misaligned (misal)
    );

    lsu_st_steer u_steer (
        .size  (size),
        .lane  (lane),
        .src   (st_data),
        .be    (be_raw),
        .wdata (mem_wdata)
    );

    always_comb begin
        fault   = req_valid && misal;
        mem_req = req_valid && !misal;
        mem_we  = mem_req && req_write;
        mem_be  = mem_we ? be_raw : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid <= 1'b0;
            ctl_q    <= '0;
        end else begin
            ld_valid <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                ctl_q.bad  <= misal;
                ctl_q.lane <= lane;
                ctl_q.size <= size;
                ctl_q.sext <= req_signed;
            end
        end
    end

    lsu_ld_align u_align (
        .ctl    (ctl_q),
        .rdata  (mem_rdata),
        .result (ld_data)
    );
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic        req_signed,
    input logic        fault,
    input logic        mem_req,
    input logic        mem_we,
    input logic [3:0]  mem_be,
    input logic        ld_valid,
    input logic [31:0] ld_data
);
    a_r8_fault_blocks_memory: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!mem_req && !mem_we));

    a_r10_load_returns: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> ld_valid);

    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !ld_valid);

    a_r9_fault_load_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && fault) |=> (ld_data == 32'h0));

    a_r2_byte_one_strobe: assert property (@(posedge clk) disable iff (rst)
        (mem_we && req_size == 2'b00) |-> ($countones(mem_be) == 1));

    a_r3_half_strobe_pair: assert property (@(posedge clk) disable iff (rst)
        (mem_we && req_size == 2'b01) |-> (mem_be == 4'b1100 || mem_be == 4'b0011));

    a_r5_unsigned_byte_high_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'b00 && !req_signed) |=> (ld_data[31:8] == 24'h0));
endmodule

bind be_lane_unit lsu_checker chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_signed (req_signed),
    .fault      (fault),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data)
);

// File: tb/be_lane_unit_test.sv
module be_lane_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] base = '0, st_data = '0;
    logic [11:0] offset = '0;
    logic        mem_req, mem_we, fault, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_be;

    int total = 0, bad = 0;
    bit done = 0;

    logic [31:0] mem [0:15];
    logic [7:0]  mdl [0:63];

    always #5 clk = ~clk;

    be_lane_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .base(base), .offset(offset),
        .st_data(st_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fault(fault),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) mem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[5:2]];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit misal(input int a, input int sz);
        if (sz == 0) return 0;
        if (sz == 1) return (a % 2) != 0;
        if (sz == 2) return (a % 4) != 0;
        return 1;
    endfunction

    function automatic logic [3:0] exp_be(input int a, input int sz);
        if (sz == 0) return 4'b1000 >> (a % 4);
        if (sz == 1) return ((a % 4) == 0) ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_load(input int a, input int sz, input bit sg);
        logic [31:0] v;
        if (misal(a, sz)) return 32'h0;
        if (sz == 0) begin
            v = {24'h0, mdl[a]};
            if (sg && v[7]) v[31:8] = '1;
        end else if (sz == 1) begin
            v = {16'h0, mdl[a], mdl[a+1]};
            if (sg && v[15]) v[31:16] = '1;
        end else begin
            v = {mdl[a], mdl[a+1], mdl[a+2], mdl[a+3]};
        end
        return v;
    endfunction

    function automatic void model_store(input int a, input int sz, input logic [31:0] d);
        if (misal(a, sz)) return;
        if (sz == 0) mdl[a] = d[7:0];
        else if (sz == 1) begin mdl[a] = d[15:8]; mdl[a+1] = d[7:0]; end
        else begin mdl[a] = d[31:24]; mdl[a+1] = d[23:16]; mdl[a+2] = d[15:8]; mdl[a+3] = d[7:0]; end
    endfunction

    // Drive a request; base and offset are chosen so their sum is a.
    task automatic drive(input int a, input bit wr, input int sz, input bit sg, input logic [31:0] d, input int delta);
        req_valid  = 1'b1;
        req_write  = wr;
        req_size   = sz[1:0];
        req_signed = sg;
        base       = 32'(a - delta);
        offset     = 12'(delta);
        st_data    = d;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic do_store(input int a, input int sz, input logic [31:0] d, input int delta, input string tag);
        bit mis;
        mis = misal(a, sz);
        @(negedge clk);
        drive(a, 1'b1, sz, 1'b0, d, delta);
        #1;
        chk(fault == mis, {tag, " fault flag"}, 32'(fault), 32'(mis));
        if (mis) begin
            chk(!mem_req && !mem_we, "R8 no memory access on fault", {30'h0, mem_req, mem_we}, 32'h0);
        end else begin
            chk(mem_we && mem_be == exp_be(a, sz), {tag, " strobes"}, {27'h0, mem_we, mem_be}, {27'h0, 1'b1, exp_be(a, sz)});
            chk(mem_addr == 32'(a & ~3), "R1 word address", mem_addr, 32'(a & ~3));
        end
        @(negedge clk);
        idle();
        #1;
        chk(!ld_valid, "R10 store raises no ld_valid", 32'(ld_valid), 32'h0);
        model_store(a, sz, d);
    endtask

    task automatic do_load(input int a, input int sz, input bit sg, input int delta, input string tag);
        logic [31:0] e;
        bit mis;
        e   = exp_load(a, sz, sg);
        mis = misal(a, sz);
        @(negedge clk);
        drive(a, 1'b0, sz, sg, 32'h0, delta);
        #1;
        chk(fault == mis, mis ? "R8 load fault flag" : {tag, " no fault"}, 32'(fault), 32'(mis));
        @(negedge clk);
        idle();
        #1;
        chk(ld_valid, "R10 ld_valid one cycle after load", 32'(ld_valid), 32'h1);
        chk(ld_data == e, mis ? "R9 faulty load returns zero" : tag, ld_data, e);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        string t;
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        for (int i = 0; i < 64; i++) mdl[i] = 8'h0;

        repeat (3) @(negedge clk);
        chk(!ld_valid && !mem_req, "R11 outputs quiet in reset", {30'h0, ld_valid, mem_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!ld_valid && !mem_req, "R11 outputs quiet after reset", {30'h0, ld_valid, mem_req}, 32'h0);

        // Fill with word stores, using positive and negative offsets (R1, R4).
        for (int w = 0; w < 16; w++) begin
            logic [31:0] pat;
            pat = 32'h8F3C_71A4 ^ (32'(w) * 32'h1357_9BDF);
            do_store(4 * w, 2, pat, (w % 2 == 0) ? -300 : 700, "R4 word store");
        end

        // Sweep every address, size and sign mode.
        for (int a = 0; a < 60; a++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    t = (sz == 0) ? "R5 byte load" : (sz == 1) ? "R6 halfword load" : "R7 word load";
                    do_load(a, sz, sg[0], (a % 3 == 0) ? -17 : 9, t);
                end
            end
        end

        // Narrow stores at every offset, including misaligned halves.
        for (int a = 16; a < 32; a++) begin
            do_store(a, 0, 32'hDEAD_BE00 | 32'(a * 7), 5, "R2 byte store");
        end
        for (int a = 32; a < 48; a++) begin
            do_store(a, 1, 32'hFFFF_0000 | 32'(a * 32'h0301), -40, "R3 halfword store");
        end
        for (int a = 49; a < 60; a++) begin
            if (a % 4 != 0) do_store(a, 2, 32'hA5A5_A5A5, 12, "R8 misaligned word store");
        end
        do_store(8, 3, 32'h1234_5678, 0, "R8 reserved size store");
        for (int a = 0; a < 60; a += 4) do_load(a, 2, 1'b0, 3, "R7 word readback after stores");

        // Load return overlapping a store in the same cycle.
        for (int a = 0; a < 16; a += 2) begin
            logic [31:0] e;
            e = exp_load(a, 1, 1'b1);
            @(negedge clk);
            drive(a, 1'b0, 1, 1'b1, 32'h0, 2);
            @(negedge clk);
            drive(a ^ 2, 1'b1, 0, 1'b0, 32'h0000_00C0 + 32'(a), -6);
            #1;
            chk(ld_valid && ld_data == e, "R6 load result beside store", ld_data, e);
            chk(mem_be == exp_be(a ^ 2, 0), "R2 store strobe beside load return", {28'h0, mem_be}, {28'h0, exp_be(a ^ 2, 0)});
            @(negedge clk);
            idle();
            #1;
            chk(!ld_valid, "R10 no ld_valid after store", 32'(ld_valid), 32'h0);
            model_store(a ^ 2, 0, 32'h0000_00C0 + 32'(a));
        end
        do_load(3, 3, 1'b1, 0, "R9 reserved size load");
        for (int a = 0; a < 16; a += 4) do_load(a, 2, 1'b0, -1, "R2 word readback after overlap");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule